// File: doc/BRIEF.md
# SPI word packer and unpacker

This block sits between byte-oriented buffers and the 32-bit word FIFOs of a serial engine whose word length can be set anywhere from 4 to 32 bits. On the transmit path it gathers bytes from a stream and emits one FIFO word per serial word. The first byte of each word is placed in the top byte lane, so transmit words are left-justified. On the receive path it takes FIFO words and hands their bytes out one at a time. Receive words are right-justified, so the first byte comes from the highest byte lane that the word length uses.

A transfer begins with a one-cycle `start` pulse. On that pulse the block latches the word-length field, the total byte count and two flags that say whether a transmit source and a receive sink exist. The number of bytes per word is the bit count divided by eight, rounded up. The last word of a transfer carries only the bytes that remain. When no transmit source exists, the block pushes zero words so that the transfer still completes. When no receive sink exists, it consumes received words and throws them away. Each direction pulses its own done signal once its byte count has been covered.

Top module: `spi_word_packer`

## Requirements
- R1: `bpw_m1` holds the bits per word minus one. Bytes per word are w = bpw_m1/8 + 1 (integer division), which gives 1 for bpw_m1 = 3..7, 2 for 8..15, 3 for 16..23 and 4 for 24..31. If `start` arrives with bpw_m1 < 3 or with `xfer_len` = 0, `cfg_err` goes high and stays high until the next start. While it is high, `txb_ready`, `txw_valid`, `rxw_ready` and `rxb_valid` all stay low.
- R2: On transmit, the i-th byte of a word (counting from 0) lands in `txw_data` bits [31-8i : 24-8i]. The first byte is therefore always in bits 31:24.
- R3: Each transmit word carries min(w, bytes remaining) bytes. In a partial last word, every bit below the last byte written is zero.
- R4: On receive, the i-th byte handed out from a word is `rxw_data` bits [8(w-1-i)+7 : 8(w-1-i)]. So w=4 turns 0x12345678 into 12,34,56,78; w=2 turns 0x00001234 into 12,34; and w=1 turns 0x00000012 into 12.
- R5: The final receive word yields only min(w, bytes remaining) bytes, taken with the same lane rule as R4. The block then accepts no further word.
- R6: With `tx_en` low at start, `txb_ready` stays low and zero words are offered on `txw_*` until the byte count is covered.
- R7: With `rx_en` low at start, received words are accepted and dropped. `rxb_valid` stays low, and the byte count still advances.
- R8: `tx_done` is high for exactly one cycle, in the cycle after the word handshake that covers the byte count. `rx_done` does the same after the last byte handshake, or after the last word when words are being dropped.
- R9: `start` abandons any transfer in progress. It clears partial words and both byte counters, and a valid start clears `cfg_err`.
- R10: While `txw_valid` is high and `txw_ready` is low, `txw_data` holds its value. The same applies to `rxb_data` while `rxb_valid` is high and `rxb_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new transfer; latches the configuration |
| bpw_m1 | input | 5 | Bits per word minus one |
| xfer_len | input | LEN_W | Total bytes in the transfer |
| tx_en | input | 1 | A transmit byte source exists |
| rx_en | input | 1 | A receive byte sink exists |
| txb_valid | input | 1 | Transmit byte offered |
| txb_ready | output | 1 | Transmit byte accepted |
| txb_data | input | 8 | Transmit byte |
| txw_valid | output | 1 | Transmit FIFO word offered |
| txw_ready | input | 1 | Transmit FIFO word taken |
| txw_data | output | 32 | Transmit FIFO word, left-justified |
| rxw_valid | input | 1 | Receive FIFO word offered |
| rxw_ready | output | 1 | Receive FIFO word accepted |
| rxw_data | input | 32 | Receive FIFO word, right-justified |
| rxb_valid | output | 1 | Receive byte offered |
| rxb_ready | input | 1 | Receive byte taken |
| rxb_data | output | 8 | Receive byte |
| cfg_err | output | 1 | Last start carried an invalid configuration |
| tx_done | output | 1 | One-cycle pulse when the transmit count is covered |
| rx_done | output | 1 | One-cycle pulse when the receive count is covered |

## Verification
A byte-lane index that has gone wrong shows up in the very first word presented after the fault, because the bytes land in the wrong lane of `txw_data` or come out of `rxb_data` in the wrong order. A byte counter that has drifted either cuts the last word short, or adds bytes, or moves `tx_done` and `rx_done` by at least one word. The bench catches this at the final handshake of each transfer. Stale state that survives a restart appears as leftover bytes in the first word after the new start.

// File: rtl/spi_word_packer.sv
module spi_word_packer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       bpw_m1,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             txb_valid,
  output logic             txb_ready,
  input  logic [7:0]       txb_data,
  output logic             txw_valid,
  input  logic             txw_ready,
  output logic [31:0]      txw_data,
  input  logic             rxw_valid,
  output logic             rxw_ready,
  input  logic [31:0]      rxw_data,
  output logic             rxb_valid,
  input  logic             rxb_ready,
  output logic [7:0]       rxb_data,
  output logic             cfg_err,
  output logic             tx_done,
  output logic             rx_done
);

  logic             bad_cfg;
  logic [2:0]       w_new;
  logic [2:0]       w_q;
  logic             txen_q, rxen_q;

  logic             tx_act, tx_full;
  logic [LEN_W-1:0] tx_left;
  logic [1:0]       tx_bi;
  logic [31:0]      tx_acc;
  logic [2:0]       tx_nb;

  logic             rx_act, rx_hold;
  logic [LEN_W-1:0] rx_left;
  logic [1:0]       rx_bi;
  logic [31:0]      rx_word;
  logic [2:0]       rx_nb;
  logic [2:0]       rx_sh;

  assign bad_cfg = (bpw_m1 < 5'd3) || (xfer_len == '0);
  assign w_new   = {1'b0, bpw_m1[4:3]} + 3'd1;

  assign tx_nb = (tx_left < LEN_W'(w_q)) ? tx_left[2:0] : w_q;
  assign rx_nb = (rx_left < LEN_W'(w_q)) ? rx_left[2:0] : w_q;
  assign rx_sh = w_q - 3'd1 - {1'b0, rx_bi};

  assign txb_ready = tx_act & txen_q & ~tx_full;
  assign txw_valid = tx_act & (tx_full | ~txen_q);
  assign txw_data  = tx_acc;

  assign rxw_ready = rx_act & ~rx_hold;
  assign rxb_valid = rx_hold;
  assign rxb_data  = rx_word[8*int'(rx_sh[1:0]) +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q     <= 3'd1;
      txen_q  <= 1'b0;
      rxen_q  <= 1'b0;
      cfg_err <= 1'b0;
    end else if (start) begin
      w_q     <= w_new;
      txen_q  <= tx_en;
      rxen_q  <= rx_en;
      cfg_err <= bad_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act  <= 1'b0;
      tx_full <= 1'b0;
      tx_left <= '0;
      tx_bi   <= '0;
      tx_acc  <= '0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (start) begin
        tx_act  <= ~bad_cfg;
        tx_full <= 1'b0;
        tx_left <= xfer_len;
        tx_bi   <= '0;
        tx_acc  <= '0;
      end else begin
        if (txb_valid && txb_ready) begin
          tx_acc[8*(3-int'(tx_bi)) +: 8] <= txb_data;
          if ({1'b0, tx_bi} == tx_nb - 3'd1) begin
            tx_full <= 1'b1;
            tx_bi   <= '0;
          end else begin
            tx_bi <= tx_bi + 2'd1;
          end
        end
        if (txw_valid && txw_ready) begin
          tx_acc  <= '0;
          tx_full <= 1'b0;
          tx_left <= tx_left - LEN_W'(tx_nb);
          if (tx_left == LEN_W'(tx_nb)) begin
            tx_act  <= 1'b0;
            tx_done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act  <= 1'b0;
      rx_hold <= 1'b0;
      rx_left <= '0;
      rx_bi   <= '0;
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (start) begin
        rx_act  <= ~bad_cfg;
        rx_hold <= 1'b0;
        rx_left <= xfer_len;
        rx_bi   <= '0;
      end else begin
        if (rxw_valid && rxw_ready) begin
          if (rxen_q) begin
            rx_word <= rxw_data;
            rx_hold <= 1'b1;
            rx_bi   <= '0;
          end else begin
            rx_left <= rx_left - LEN_W'(rx_nb);
            if (rx_left == LEN_W'(rx_nb)) begin
              rx_act  <= 1'b0;
              rx_done <= 1'b1;
            end
          end
        end
        if (rxb_valid && rxb_ready) begin
          if ({1'b0, rx_bi} == rx_nb - 3'd1) begin
            rx_hold <= 1'b0;
            rx_left <= rx_left - LEN_W'(rx_nb);
            if (rx_left == LEN_W'(rx_nb)) begin
              rx_act  <= 1'b0;
              rx_done <= 1'b1;
            end
          end else begin
            rx_bi <= rx_bi + 2'd1;
          end
        end
      end
    end
  end

  // R1
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !txb_ready && !txw_valid && !rxw_ready && !rxb_valid);

  // R6
  tx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txw_valid && !txen_q |-> txw_data == 32'd0);

  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxen_q |-> !rxb_valid);

  // R8
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R10
  txw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txw_valid && !txw_ready && !start |=> txw_valid && $stable(txw_data));

  // R10
  rxb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_valid && !rxb_ready && !start |=> rxb_valid && $stable(rxb_data));

endmodule

// File: tb/spi_word_packer_test.sv
`timescale 1ns/1ps
module spi_word_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  bpw_m1 = 5'd7;
  logic [15:0] xfer_len = 16'd0;
  logic        tx_en = 1'b1, rx_en = 1'b1;
  logic        txb_valid = 1'b0, txw_ready = 1'b0, rxw_valid = 1'b0, rxb_ready = 1'b0;
  logic [7:0]  txb_data = 8'd0;
  logic [31:0] rxw_data = 32'd0;
  logic        txb_ready, txw_valid, rxw_ready, rxb_valid, cfg_err, tx_done, rx_done;
  logic [31:0] txw_data;
  logic [7:0]  rxb_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  spi_word_packer #(.LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bpw_m1(bpw_m1), .xfer_len(xfer_len),
    .tx_en(tx_en), .rx_en(rx_en),
    .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
    .txw_valid(txw_valid), .txw_ready(txw_ready), .txw_data(txw_data),
    .rxw_valid(rxw_valid), .rxw_ready(rxw_ready), .rxw_data(rxw_data),
    .rxb_valid(rxb_valid), .rxb_ready(rxb_ready), .rxb_data(rxb_data),
    .cfg_err(cfg_err), .tx_done(tx_done), .rx_done(rx_done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [4:0] m1, input logic [15:0] len, input logic te, input logic re);
    bpw_m1 = m1; xfer_len = len; tx_en = te; rx_en = re; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    txb_valid = 1'b1; txb_data = b;
    while (!txb_ready) @(negedge clk);
    @(negedge clk);
    txb_valid = 1'b0;
  endtask

  task automatic pull_word(output logic [31:0] d, output logic dn);
    while (!txw_valid) @(negedge clk);
    d = txw_data; txw_ready = 1'b1;
    @(negedge clk);
    txw_ready = 1'b0; dn = tx_done;
  endtask

  task automatic push_word(input logic [31:0] d);
    rxw_valid = 1'b1; rxw_data = d;
    while (!rxw_ready) @(negedge clk);
    @(negedge clk);
    rxw_valid = 1'b0;
  endtask

  task automatic pull_byte(output logic [7:0] b, output logic dn);
    while (!rxb_valid) @(negedge clk);
    b = rxb_data; rxb_ready = 1'b1;
    @(negedge clk);
    rxb_ready = 1'b0; dn = rx_done;
  endtask

  task automatic t_reset;
    chk(!txw_valid && !rxb_valid && !txb_ready && !rxw_ready && !cfg_err, "reset",
        {27'd0, txw_valid, rxb_valid, txb_ready, rxw_ready, cfg_err}, 32'd0);
  endtask

  task automatic t_tx_w4;
    logic [31:0] d; logic dn;
    do_start(5'd31, 16'd6, 1'b1, 1'b1);
    push_byte(8'h01); push_byte(8'h02); push_byte(8'h03); push_byte(8'h04);
    @(negedge clk); @(negedge clk);
    chk(txw_valid && txw_data == 32'h01020304, "R10 stall", txw_data, 32'h01020304);
    pull_word(d, dn);
    chk(d == 32'h01020304, "R2 full word", d, 32'h01020304);
    chk(!dn, "R8 early done", {31'd0, dn}, 32'd0);
    push_byte(8'h05); push_byte(8'h06);
    pull_word(d, dn);
    chk(d == 32'h05060000, "R3 partial word", d, 32'h05060000);
    chk(dn, "R8 tx_done", {31'd0, dn}, 32'd1);
    @(negedge clk);
    chk(!tx_done, "R8 single pulse", {31'd0, tx_done}, 32'd0);
  endtask

  task automatic t_tx_w2;
    logic [31:0] d; logic dn;
    do_start(5'd11, 16'd3, 1'b1, 1'b1);
    push_byte(8'hAA); push_byte(8'hBB);
    pull_word(d, dn);
    chk(d == 32'hAABB0000, "R1 two-byte word", d, 32'hAABB0000);
    push_byte(8'hCC);
    pull_word(d, dn);
    chk(d == 32'hCC000000 && dn, "R3 last byte zero fill", d, 32'hCC000000);
  endtask

  task automatic t_rx_w4;
    logic [7:0] b; logic dn;
    logic [7:0] exp [6] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
    do_start(5'd31, 16'd6, 1'b1, 1'b1);
    push_word(32'h12345678);
    for (int i = 0; i < 4; i++) begin
      pull_byte(b, dn);
      chk(b == exp[i] && !dn, "R4 byte order", {24'd0, b}, {24'd0, exp[i]});
    end
    push_word(32'h9ABCDEF0);
    for (int i = 4; i < 6; i++) begin
      pull_byte(b, dn);
      chk(b == exp[i], "R5 partial bytes", {24'd0, b}, {24'd0, exp[i]});
    end
    chk(dn, "R8 rx_done", {31'd0, dn}, 32'd1);
    chk(!rxw_ready && !rxb_valid, "R5 no more words", {30'd0, rxw_ready, rxb_valid}, 32'd0);
  endtask

  task automatic t_rx_narrow;
    logic [7:0] b; logic dn;
    do_start(5'd15, 16'd2, 1'b1, 1'b1);
    push_word(32'h00001234);
    pull_byte(b, dn);
    chk(b == 8'h12, "R4 w2 first", {24'd0, b}, 32'h12);
    pull_byte(b, dn);
    chk(b == 8'h34 && dn, "R4 w2 second", {24'd0, b}, 32'h34);
    do_start(5'd7, 16'd1, 1'b1, 1'b1);
    push_word(32'h00000012);
    pull_byte(b, dn);
    chk(b == 8'h12 && dn, "R4 w1", {24'd0, b}, 32'h12);
  endtask

  task automatic t_no_tx;
    logic [31:0] d; logic dn;
    do_start(5'd15, 16'd4, 1'b0, 1'b1);
    chk(!txb_ready && txw_valid, "R6 no byte intake", {30'd0, txb_ready, txw_valid}, 32'd1);
    pull_word(d, dn);
    chk(d == 32'd0 && !dn, "R6 zero word 1", d, 32'd0);
    pull_word(d, dn);
    chk(d == 32'd0 && dn, "R6 zero word 2 done", d, 32'd0);
  endtask

  task automatic t_no_rx;
    do_start(5'd7, 16'd2, 1'b1, 1'b0);
    push_word(32'h000000AA);
    chk(!rxb_valid && !rx_done, "R7 dropped word 1", {30'd0, rxb_valid, rx_done}, 32'd0);
    push_word(32'h000000BB);
    chk(!rxb_valid && rx_done, "R7 dropped word 2 done", {30'd0, rxb_valid, rx_done}, 32'd1);
  endtask

  task automatic t_cfg;
    do_start(5'd2, 16'd4, 1'b1, 1'b1);
    chk(cfg_err && !txb_ready && !rxw_ready, "R1 short word rejected",
        {29'd0, cfg_err, txb_ready, rxw_ready}, 32'd4);
    do_start(5'd7, 16'd0, 1'b1, 1'b1);
    chk(cfg_err && !txb_ready, "R1 zero length rejected", {30'd0, cfg_err, txb_ready}, 32'd2);
    do_start(5'd7, 16'd1, 1'b1, 1'b1);
    chk(!cfg_err && txb_ready, "R9 valid start clears error", {30'd0, cfg_err, txb_ready}, 32'd1);
  endtask

  task automatic t_restart;
    logic [31:0] d; logic dn;
    do_start(5'd31, 16'd8, 1'b1, 1'b1);
    push_byte(8'hAA); push_byte(8'hBB);
    do_start(5'd7, 16'd1, 1'b1, 1'b1);
    push_byte(8'h5A);
    pull_word(d, dn);
    chk(d == 32'h5A000000 && dn, "R9 restart clears partial word", d, 32'h5A000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_w4();
    t_tx_w2();
    t_rx_w4();
    t_rx_narrow();
    t_no_tx();
    t_no_rx();
    t_cfg();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule